// File: doc/BRIEF.md
# Alert Logging Slave for a Shared SPI/I2C Backplane

This block is a slave on a modular backplane where SPI and I2C traffic share the same wires. It watches the SPI clock line, a shared active-low select line (which also serves as the I2C clock) and a three-bit device-address field. When the select line is low and the address field carries the block's own code, the block takes a snapshot of the per-slot alert inputs. It then presents that snapshot, most significant bit first, on the controller-in data line, one bit per SPI clock. A host that sees an alert reads the snapshot to find out which slot raised it.

The block's address is the all-ones code. During I2C traffic the bus holds the address lines high and the SPI clock high, so the block is selected and deselected constantly without any SPI clock edge. Each such selection only re-captures the alerts and presents the top bit; nothing is shifted. All bus pins and alert inputs pass through two-flop synchronisers into the 125 MHz system clock domain. The data line is driven only while the block is selected; otherwise the output enable is low and the line is released.

Top module: `alert_log_slave`

## Requirements
- R1: The block counts as selected only when the select input is low and the address input equals 3'b111 (parameter MY_ADDR). Any other address, or a high select, keeps `miso_oe` low even while the SPI clock toggles.
- R2: While `miso_oe` is low, `miso_o` is 0.
- R3: The alert vector is captured once, when selection begins. Changes on `slot_alert` during a selection do not alter the bits presented.
- R4: Bit SLOTS-1 of the snapshot is presented first, before any SPI clock edge. Each falling edge of the SPI clock seen while selected advances to the next lower bit (data changes on the falling edge and is valid at the rising edge).
- R5: While selected, nothing shifts unless the SPI clock falls. With the clock held high and the select line toggling (I2C traffic), each new selection presents bit SLOTS-1 of a fresh snapshot.
- R6: After SLOTS falling edges within one selection, every further bit presented is 0.
- R7: During and right after reset, `miso_oe` and `miso_o` are 0.
- R8: A change on the bus pins reaches `miso_oe` on the third rising clock edge after it, through two synchroniser stages and one output register.

Parameters: SLOTS (default 8) sets the width of the alert vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversamples the bus) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sck | input | 1 | Backplane SPI clock line |
| bus_sel_n | input | 1 | Shared select line, active low (I2C clock during I2C traffic) |
| bus_addr | input | 3 | Device-address field |
| slot_alert | input | SLOTS | Per-slot alert inputs, asynchronous |
| miso_o | output | 1 | Controller-in data value |
| miso_oe | output | 1 | Drive enable for the controller-in line; low means released |

## Verification
The assertions assume that the bus pins change far more slowly than the system clock, so that every level seen by the synchronisers lasts several cycles and no edge is lost. The bench holds each SPI clock level and each select level for at least four system clocks. It changes `slot_alert` only while the block is deselected, except in the test that deliberately disturbs it mid-transfer. It also keeps the bus idle through reset and for several cycles after it, so the state right after reset matches the idle bus the model starts from.

// File: rtl/alert_log_pkg.sv
package alert_log_pkg;
  localparam int unsigned BUS_ADDR_W = 3;

  typedef struct packed {
    logic                  sck;
    logic                  sel_n;
    logic [BUS_ADDR_W-1:0] addr;
  } bus_pins_t;

  localparam int unsigned BUS_PINS_W = $bits(bus_pins_t);
  localparam bus_pins_t   BUS_IDLE   = '{sck: 1'b0, sel_n: 1'b1, addr: '0};
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_rest
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import alert_log_pkg::*;
#(
  parameter logic [BUS_ADDR_W-1:0] MY_ADDR = '1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bus_pins_t pins,
  output logic      sel_now,
  output logic      sel_prev,
  output logic      sck_fall,
  output logic      load_en,
  output logic      shift_en,
  output logic      oe
);
  logic sel_prev_d, sck_prev_q, sck_prev_d, oe_d;

  always_comb begin
    sel_now    = !pins.sel_n && (pins.addr == MY_ADDR);
    sck_fall   = sck_prev_q && !pins.sck;
    load_en    = sel_now && !sel_prev;
    shift_en   = sel_now && sel_prev && sck_fall;
    sel_prev_d = sel_now;
    sck_prev_d = pins.sck;
    oe_d       = sel_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev   <= 1'b0;
      sck_prev_q <= 1'b0;
      oe         <= 1'b0;
    end else begin
      sel_prev   <= sel_prev_d;
      sck_prev_q <= sck_prev_d;
      oe         <= oe_d;
    end
  end
endmodule

// File: rtl/alert_shreg.sv
module alert_shreg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] shreg,
  output logic             msb
);
  logic [WIDTH-1:0] shreg_d;

  always_comb begin
    shreg_d = shreg;
    if (load_en)       shreg_d = din;
    else if (shift_en) shreg_d = {shreg[WIDTH-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= shreg_d;
  end

  assign msb = shreg[WIDTH-1];
endmodule

// File: rtl/alert_log_slave.sv
module alert_log_slave
  import alert_log_pkg::*;
#(
  parameter int unsigned           SLOTS       = 8,
  parameter int unsigned           SYNC_STAGES = 2,
  parameter logic [BUS_ADDR_W-1:0] MY_ADDR     = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sck,
  input  logic                  bus_sel_n,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [SLOTS-1:0]      slot_alert,
  output logic                  miso_o,
  output logic                  miso_oe
);
  logic             rst_i_n;
  bus_pins_t        pins_raw, pins_s;
  logic [SLOTS-1:0] alert_s;
  logic [SLOTS-1:0] shreg;
  logic             sel_now, sel_prev, sck_fall, load_en, shift_en, oe, msb;

  always_comb pins_raw = '{sck: bus_sck, sel_n: bus_sel_n, addr: bus_addr};

  rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i_n)
  );

  bus_sync #(.WIDTH(BUS_PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_pin_sync (
    .clk(clk), .rst_n(rst_i_n), .din(pins_raw), .dout(pins_s)
  );

  bus_sync #(.WIDTH(SLOTS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_alert_sync (
    .clk(clk), .rst_n(rst_i_n), .din(slot_alert), .dout(alert_s)
  );

  xfer_ctrl #(.MY_ADDR(MY_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .pins(pins_s),
    .sel_now(sel_now), .sel_prev(sel_prev), .sck_fall(sck_fall),
    .load_en(load_en), .shift_en(shift_en), .oe(oe)
  );

  alert_shreg #(.WIDTH(SLOTS)) u_shreg (
    .clk(clk), .rst_n(rst_i_n), .load_en(load_en), .shift_en(shift_en),
    .din(alert_s), .shreg(shreg), .msb(msb)
  );

  assign miso_oe = oe;
  assign miso_o  = oe & msb;
endmodule

// File: rtl/alert_log_slave_chk.sv
module alert_log_slave_chk #(
  parameter int unsigned SLOTS = 8
) (
  input logic             clk,
  input logic             rst_i_n,
  input logic             miso_o,
  input logic             miso_oe,
  input logic             sel_now,
  input logic             sel_prev,
  input logic             sck_fall,
  input logic [SLOTS-1:0] alert_s,
  input logic [SLOTS-1:0] shreg
);
  a_r2_released_low: assert property (@(posedge clk) disable iff (!rst_i_n)
    !miso_oe |-> !miso_o);

  a_r1_oe_follows_select: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sel_now |=> !miso_oe);

  a_r3_snapshot_on_entry: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_now && !sel_prev) |=> shreg == $past(alert_s));

  a_r5_hold_without_fall: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_now && sel_prev && !sck_fall) |=> $stable(shreg));

  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_now && sel_prev && sck_fall) |=> !shreg[0]);

  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_i_n |-> (!miso_oe && !miso_o));
endmodule

bind alert_log_slave alert_log_slave_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .miso_o(miso_o), .miso_oe(miso_oe),
  .sel_now(sel_now), .sel_prev(sel_prev), .sck_fall(sck_fall),
  .alert_s(alert_s), .shreg(shreg)
);

// File: tb/tb_alert_log_slave.sv
`timescale 1ns/1ps
module tb_alert_log_slave;
  localparam int SLOTS = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_sck = 1'b0;
  logic             bus_sel_n = 1'b1;
  logic [2:0]       bus_addr = 3'd0;
  logic [SLOTS-1:0] slot_alert = '0;
  logic             miso_o, miso_oe;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    running = 1'b0;
  string tag = "R7";

  always #4 clk = ~clk;

  alert_log_slave #(.SLOTS(SLOTS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sck(bus_sck), .bus_sel_n(bus_sel_n),
    .bus_addr(bus_addr), .slot_alert(slot_alert),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  // Behavioural reference: two-sample pin delay, bit index counter.
  logic [SLOTS+4:0] hist1 = {1'b0, 1'b1, 3'd0, {SLOTS{1'b0}}};
  logic [SLOTS+4:0] hist2 = {1'b0, 1'b1, 3'd0, {SLOTS{1'b0}}};
  logic [SLOTS+4:0] seen;
  logic [SLOTS-1:0] snap = '0;
  int  idx = SLOTS;
  bit  m_oe = 0, m_prev = 0, m_sckp = 0, m_sel;

  always @(posedge clk) begin
    seen  = hist2;
    hist2 = hist1;
    hist1 = {bus_sck, bus_sel_n, bus_addr, slot_alert};
    m_sel = !seen[SLOTS+3] && (seen[SLOTS+2:SLOTS] == 3'd7);
    if (m_sel && !m_prev) begin
      snap = seen[SLOTS-1:0];
      idx  = 0;
    end else if (m_sel && m_prev && m_sckp && !seen[SLOTS+4]) begin
      idx++;
    end
    m_oe   = m_sel;
    m_prev = m_sel;
    m_sckp = seen[SLOTS+4];
  end

  function automatic bit exp_bit();
    if (!m_oe || idx >= SLOTS) return 1'b0;
    return snap[SLOTS-1-idx];
  endfunction

  task automatic check(input string t, input logic got, input logic exp, input string what);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", t, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check(tag, miso_oe, m_oe, "miso_oe");
      check(tag, miso_o, exp_bit(), "miso_o");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sck_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      bus_sck = 1'b1; wait_clks(4);
      bus_sck = 1'b0; wait_clks(4);
    end
  endtask

  task automatic spi_read(input logic [2:0] a, input logic [SLOTS-1:0] al, input int pulses);
    slot_alert = al; wait_clks(4);
    bus_addr = a; wait_clks(2);
    bus_sel_n = 1'b0; wait_clks(6);
    sck_pulses(pulses);
    bus_sel_n = 1'b1; wait_clks(6);
  endtask

  initial begin
    // R7: reset state
    wait_clks(3);
    check("R7", miso_oe, 1'b0, "miso_oe in reset");
    check("R7", miso_o, 1'b0, "miso_o in reset");
    rst_n = 1'b1;
    wait_clks(8);
    check("R7", miso_oe, 1'b0, "miso_oe after reset");
    running = 1'b1;

    // R1: other addresses never enable the output
    tag = "R1";
    for (int a = 0; a < 7; a++) spi_read(3'(a), 8'hFF, 3);

    // R8: latency from select pin to enable
    tag = "R8";
    slot_alert = 8'h81; bus_addr = 3'd7; wait_clks(4);
    bus_sel_n = 1'b0;
    wait_clks(2);
    check("R8", miso_oe, 1'b0, "miso_oe two edges after select");
    wait_clks(1);
    check("R8", miso_oe, 1'b1, "miso_oe three edges after select");
    check("R8", miso_o, 1'b1, "first bit of 8'h81");
    wait_clks(4);
    bus_sel_n = 1'b1; wait_clks(6);

    // R4: MSB first, one bit per falling edge
    tag = "R4";
    spi_read(3'd7, 8'hA5, 8);
    spi_read(3'd7, 8'h5A, 8);

    // R6: extra clocks produce zeros
    tag = "R6";
    spi_read(3'd7, 8'hFF, 12);

    // R3: alert changes during a transfer are not seen
    tag = "R3";
    slot_alert = 8'h3C; bus_addr = 3'd7; wait_clks(4);
    bus_sel_n = 1'b0; wait_clks(6);
    sck_pulses(2);
    slot_alert = 8'hC3;
    sck_pulses(6);
    bus_sel_n = 1'b1; wait_clks(6);

    // R5: I2C-style traffic, clock held high, select toggling
    tag = "R5";
    bus_sck = 1'b1; bus_addr = 3'd7; wait_clks(6);
    for (int i = 0; i < 12; i++) begin
      slot_alert = (i % 2 == 0) ? 8'h80 : 8'h7F;
      wait_clks(4);
      bus_sel_n = 1'b0; wait_clks(8);
      bus_sel_n = 1'b1; wait_clks(5);
    end
    bus_sck = 1'b0; wait_clks(6);

    // R2: output released after deselection
    tag = "R2";
    spi_read(3'd7, 8'hFF, 1);
    wait_clks(4);
    check("R2", miso_oe, 1'b0, "miso_oe after deselect");
    check("R2", miso_o, 1'b0, "miso_o after deselect");

    running = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule